// File: doc/BRIEF.md
# Pipelined Single-Precision Log2 Converter

This block takes a 32-bit IEEE-754 single-precision operand and returns its base-2 logarithm as a signed fixed-point value with eight integer and eight fractional bits. It uses the structure of the float format directly. Once the bias is removed, the biased exponent field already gives the whole-number part of the logarithm. A normalized significand always lies in [1,2), so the fractional part needs only a small 16-entry lookup that covers that one octave. The lookup is indexed by the four most significant stored significand bits, and there is no normalization shifter.

The datapath has three register stages and takes one operand on every clock. A valid bit travels with each operand. Operands that have no real logarithm in this format raise an error flag and produce a zero result: a set sign bit, an exponent field of zero (zero and subnormal encodings) or an exponent field of all ones (infinity and NaN). The significand bits below the lookup index are truncated.

Top module: `fplog2_pipe`

## Requirements
- R1: A result appears on `out_valid`/`out_log`/`out_err` exactly 3 clock edges after the operand is sampled with `in_valid` high. `out_valid` is a copy of `in_valid` delayed by 3 cycles.
- R2: For a valid non-error operand with exponent field E (bits 30:23), `out_log[15:8]` equals E-127 in two's complement. This covers the range -126 to +127.
- R3: For a valid non-error operand, `out_log[7:0]` equals round(log2(1 + k/16) * 256), where k is bits 22:19. Bits 18:0 have no effect on the result.
- R4: An operand with bit 31 set gives `out_err` = 1 and `out_log` = 0.
- R5: An operand with exponent field 0 gives `out_err` = 1 and `out_log` = 0.
- R6: An operand with exponent field 255 (infinity or NaN) gives `out_err` = 1 and `out_log` = 0.
- R7: Whenever `out_valid` is low, `out_log` and `out_err` are both 0.
- R8: Operands presented on consecutive cycles each produce their own result on consecutive cycles, in order, with none lost or duplicated.
- R9: When `rst_n` is sampled low, all stages clear, so operands already in the pipe never come out. After reset `out_valid`, `out_err` and `out_log` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_float` as an operand this cycle |
| in_float | input | 32 | Single-precision operand |
| out_valid | output | 1 | Marks a result on `out_log`/`out_err` |
| out_log | output | 16 | Signed log2 result, 8 integer and 8 fraction bits |
| out_err | output | 1 | Operand had no representable logarithm |

## Verification
A wrong state in a stage shows at the outputs exactly three cycles after the bad operand enters. A corrupted exponent register moves the upper byte by a whole unit. A wrong index or lookup entry moves only the lower byte. A lost error bit lets a nonzero value out with `out_err` low. A stuck or skipped valid bit breaks the one-result-per-operand count, or breaks the zero result seen in idle cycles. The bench sends every exponent together with every lookup index through the pipe without gaps and with bubbles, so that each of these faults appears within a few cycles of its cause.

// File: rtl/fl2_pkg.sv
// Shared widths, stage records and the fractional lookup for the log2 pipe.
// Assumes IEEE-754 single precision and a 4-bit, 16-entry one-octave table.
package fl2_pkg;

    localparam int SIGN_POS = 31;
    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int BIAS     = 127;
    localparam int IDX_W    = 4;
    localparam int FRAC_W   = 8;
    localparam int OUT_W    = EXP_W + FRAC_W;
    localparam int WORD_W   = 1 + EXP_W + MAN_W;
    localparam int IDX_LO   = MAN_W - IDX_W;
    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;

    // Record held after the unpack stage.
    typedef struct packed {
        logic             vld;
        logic             err;
        logic [EXP_W-1:0] bexp;
        logic [IDX_W-1:0] idx;
    } unpack_t;

    // Record held after the lookup stage.
    typedef struct packed {
        logic              vld;
        logic              err;
        logic [EXP_W-1:0]  ipart;
        logic [FRAC_W-1:0] fpart;
    } part_t;

    // round(log2(1 + k/16) * 256) for k = 0..15
    function automatic logic [FRAC_W-1:0] frac_rom(input logic [IDX_W-1:0] k);
        logic [FRAC_W-1:0] v;
        case (k)
            4'd0:  v = 8'd0;
            4'd1:  v = 8'd22;
            4'd2:  v = 8'd44;
            4'd3:  v = 8'd63;
            4'd4:  v = 8'd82;
            4'd5:  v = 8'd100;
            4'd6:  v = 8'd118;
            4'd7:  v = 8'd134;
            4'd8:  v = 8'd150;
            4'd9:  v = 8'd165;
            4'd10: v = 8'd179;
            4'd11: v = 8'd193;
            4'd12: v = 8'd207;
            4'd13: v = 8'd220;
            4'd14: v = 8'd232;
            default: v = 8'd244;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fl2_unpack.sv
// Stage 1: splits the float into exponent and lookup index and classifies it.
// Assumes subnormals are not supplied; exponent 0 is flagged like zero.
module fl2_unpack
    import fl2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_float,
    output unpack_t           st_q
);

    logic [EXP_W-1:0] bexp_w;
    logic             bad_w;

    // Field extraction and operand classification.
    always_comb begin
        bexp_w = in_float[MAN_W +: EXP_W];
        bad_w  = in_float[SIGN_POS] | (bexp_w == '0) | (bexp_w == EXP_ALL1);
    end

    // Stage register: valid always advances, fields load only with an operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q.vld <= in_valid;
            if (in_valid) begin
                st_q.err  <= bad_w;
                st_q.bexp <= bexp_w;
                st_q.idx  <= in_float[IDX_LO +: IDX_W];
            end
        end
    end

endmodule

// File: rtl/fl2_frac_lut.sv
// Stage 2: removes the exponent bias and looks up the fractional log.
// Assumes the index comes from a normalized significand in [1,2).
module fl2_frac_lut
    import fl2_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  unpack_t st_d,
    output part_t   st_q
);

    logic [EXP_W-1:0] ipart_w;

    // Unbias: modulo-2^EXP_W subtraction yields two's complement E-127.
    always_comb begin
        ipart_w = st_d.bexp - EXP_W'(BIAS);
    end

    // Stage register: valid always advances, data loads only with an operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q.vld <= st_d.vld;
            if (st_d.vld) begin
                st_q.err   <= st_d.err;
                st_q.ipart <= ipart_w;
                st_q.fpart <= frac_rom(st_d.idx);
            end
        end
    end

endmodule

// File: rtl/fl2_assemble.sv
// Stage 3: joins integer and fraction, forces zero on error and on idle.
// Assumes the fraction is non-negative so the bytes concatenate directly.
module fl2_assemble
    import fl2_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  part_t                   st_d,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_log,
    output logic                    out_err
);

    logic                    pass_w;
    logic signed [OUT_W-1:0] joined_w;

    // Gate: only valid, error-free operands carry a value.
    always_comb begin
        pass_w   = st_d.vld & ~st_d.err;
        joined_w = pass_w ? {st_d.ipart, st_d.fpart} : '0;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_log   <= '0;
        end else begin
            out_valid <= st_d.vld;
            out_err   <= st_d.vld & st_d.err;
            out_log   <= joined_w;
        end
    end

endmodule

// File: rtl/fplog2_pipe.sv
// Top: three-stage single-precision log2 converter, one operand per clock.
// Assumes normalized inputs; error cases produce zero with out_err set.
module fplog2_pipe
    import fl2_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [31:0]             in_float,
    output logic                    out_valid,
    output logic signed [15:0]      out_log,
    output logic                    out_err
);

    unpack_t s1_q;
    part_t   s2_q;

    fl2_unpack u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_float (in_float),
        .st_q     (s1_q)
    );

    fl2_frac_lut u_lut (
        .clk   (clk),
        .rst_n (rst_n),
        .st_d  (s1_q),
        .st_q  (s2_q)
    );

    fl2_assemble u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_d      (s2_q),
        .out_valid (out_valid),
        .out_log   (out_log),
        .out_err   (out_err)
    );

endmodule

// File: rtl/fplog2_pipe_chk.sv
// Checker for fplog2_pipe: relates outputs to inputs three cycles earlier.
// A warm-up counter keeps $past inside the cycles since reset.
module fplog2_pipe_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [31:0]        in_float,
    input logic               out_valid,
    input logic signed [15:0] out_log,
    input logic               out_err
);

    logic [1:0] age_q;

    // Count clean edges since reset, saturating at the pipe depth.
    always_ff @(posedge clk) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_int_part_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && out_valid && !out_err) |->
            (out_log[15:8] == 8'($past(in_float[30:23], 3) - 8'd127)));

    assert_err_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && out_valid) |->
            (out_err == ($past(in_float[31], 3) || $past(in_float[30:23], 3) == 8'd0
                         || $past(in_float[30:23], 3) == 8'hFF)));

    assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_log == 16'sd0));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_log == 16'sd0 && !out_err));

    assert_frac_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_log[7:0] <= 8'd244));

endmodule

bind fplog2_pipe fplog2_pipe_chk chk_i (.*);

// File: tb/fplog2_pipe_tb_top.sv
module fplog2_pipe_tb_top;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [31:0]        in_float = '0;
    logic               out_valid;
    logic signed [15:0] out_log;
    logic               out_err;

    int n_run  = 0;
    int n_fail = 0;
    int wr = 0;
    int rd = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    logic [31:0] q_in  [8192];
    logic        q_err [8192];
    logic [15:0] q_val [8192];

    always #2.5 clk = ~clk;

    fplog2_pipe dut_i (.*);

    typedef struct packed {
        logic [31:0] f;
        logic        e;
        logic [15:0] q;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h3F800000, 1'b0, 16'h0000},
        '{32'h40000000, 1'b0, 16'h0100},
        '{32'h3F000000, 1'b0, 16'hFF00},
        '{32'h40400000, 1'b0, 16'h0196},
        '{32'h3FC00000, 1'b0, 16'h0096},
        '{32'h3FC7FFFF, 1'b0, 16'h0096},
        '{32'h3F400000, 1'b0, 16'hFF96},
        '{32'h41200000, 1'b0, 16'h0352},
        '{32'h7F7FFFFF, 1'b0, 16'h7FF4},
        '{32'h00800000, 1'b0, 16'h8200},
        '{32'hBF800000, 1'b1, 16'h0000},
        '{32'h00000000, 1'b1, 16'h0000},
        '{32'h7F800000, 1'b1, 16'h0000},
        '{32'h7FC00000, 1'b1, 16'h0000}
    };

    // Reference from the requirements: R2 integer byte, R3 rounded fraction, R4-R6 errors.
    function automatic logic [16:0] ref_out(input logic [31:0] f);
        int  e;
        int  k;
        int  fr;
        real r;
        e = int'(f[30:23]);
        k = int'(f[22:19]);
        if (f[31] || e == 0 || e == 255) return {1'b1, 16'h0000};
        r  = $ln(1.0 + k / 16.0) / $ln(2.0) * 256.0;
        fr = $rtoi(r + 0.5);
        return {1'b0, 16'((e - 127) * 256 + fr)};
    endfunction

    function automatic string req_of(input logic [31:0] f);
        if (f[31])             return "R4";
        if (f[30:23] == 8'd0)  return "R5";
        if (f[30:23] == 8'hFF) return "R6";
        return "R2/R3";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic send(input logic [31:0] f, input logic e, input logic [15:0] q);
        @(negedge clk);
        in_valid = 1'b1;
        in_float = f;
        q_in[wr]  = f;
        q_err[wr] = e;
        q_val[wr] = q;
        wr++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_float = 32'hDEADBEEF;
        end
    endtask

    // Stream monitor: every result must match the next queued expectation (R1, R8).
    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            if (rd >= wr) begin
                n_run++;
                n_fail++;
                $display("FAIL R8 actual=extra-result expected=none");
            end else begin
                check(req_of(q_in[rd]), {15'd0, out_err, out_log}, {15'd0, q_err[rd], q_val[rd]});
                rd++;
            end
        end else if (mon_en) begin
            check("R7", {15'd0, out_err, out_log}, 32'd0);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        check("R9", {15'd0, out_valid, 16'd0}, 32'd0);
        check("R9", {15'd0, out_err, out_log}, 32'd0);
        rst_n = 1'b1;

        // R1: exact latency, then idle zero (R7)
        @(negedge clk);
        in_valid = 1'b1;
        in_float = 32'h40000000;
        @(negedge clk);
        in_valid = 1'b0;
        in_float = 32'hFFFFFFFF;
        check("R1", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check("R1", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check("R1", {15'd0, out_valid, out_log}, {15'd0, 1'b1, 16'h0100});
        @(negedge clk);
        check("R7", {15'd0, out_valid, out_err, out_log[14:0]}, 32'd0);
        check("R7", {16'd0, out_log}, 32'd0);

        // Vector table, streamed back to back (R2-R6, R8)
        mon_en = 1'b1;
        for (int i = 0; i < NV; i++) send(VECS[i].f, VECS[i].e, VECS[i].q);
        idle(6);

        // Sweep: every exponent with every index, random low bits, occasional bubbles
        for (int e = 0; e < 256; e++) begin
            for (int k = 0; k < 16; k++) begin
                logic [31:0] f;
                logic [16:0] r;
                f = {((e + k) % 5 == 0) ? 1'b1 : 1'b0, 8'(e), 4'(k), 19'($urandom)};
                r = ref_out(f);
                send(f, r[16], r[15:0]);
                if (k == 7 && e % 3 == 0) idle(1);
            end
        end
        idle(6);
        mon_en = 1'b0;
        check("R8", 32'(rd), 32'(wr));

        // R9: operands in flight at reset never emerge
        @(negedge clk);
        in_valid = 1'b1;
        in_float = 32'h3F800000;
        @(negedge clk);
        in_float = 32'h40000000;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R9", {15'd0, out_valid, out_log}, 32'd0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule